// File: doc/BRIEF.md
# Timeslot Power-Up Sequencer

This block switches on a group of supply regulators one timeslot at a time when the chip is told to go active. Spreading the switch-on over time keeps the in-rush current down. Each supply has a small configuration field that gives the slot it belongs to. The sequencer walks the slots in ascending order. Supplies stay on once they have been enabled, so the enable set grows with each slot.

A slot ends after a fixed dwell measured in clock cycles. It also ends only once every supply that belongs to that slot reports power-good. Supplies from earlier slots do not hold the sequence back. A slot with no supplies ends on the dwell alone. If a supply in the current slot is still not good after a further timeout, the sequencer stops, holds its enables and raises a fault flag. A chip-on flag rises when the sequence starts. A single-cycle done pulse marks the end of the last slot.

Top module: `pwrup_seq`

## Requirements
- R1: After reset, `en_o` is all zero, `chip_on_o`, `done_o` and `fault_o` are 0, and `cur_slot_o` is 0. They stay this way until `start_i` is seen high.
- R2: When `start_i` is high at a clock edge in the idle state, then after that edge `chip_on_o` is 1 and `cur_slot_o` is 1. After that, `chip_on_o` stays 1 until reset.
- R3: Supply i is enabled (`en_o[i]`=1) from the first cycle in which `cur_slot_o` equals its slot field (bits `i*SLOT_W +: SLOT_W` of `slot_cfg_i`). It stays enabled in every later slot and after the sequence ends.
- R4: A supply whose slot field is 0, or is larger than N_SLOTS, is never enabled.
- R5: When every supply of the current slot already reports good, the slot lasts exactly SLOT_DLY clock cycles.
- R6: Only the power-good inputs of supplies assigned to the current slot hold the slot. A slot whose supplies become good in cycle j of the slot (counting from 0), with j at least SLOT_DLY-1, lasts j+1 cycles.
- R7: A slot with no supply assigned lasts SLOT_DLY cycles.
- R8: If a supply of the current slot is not yet good in cycle SLOT_DLY-1+PG_TMO of the slot, `fault_o` goes to 1 after that edge. From then on, `cur_slot_o` and `en_o` hold and `done_o` stays 0 until reset. Good arriving exactly in that cycle still advances the slot.
- R9: When slot N_SLOTS ends, `done_o` is 1 for exactly one cycle. `cur_slot_o` then stays at N_SLOTS.
- R10: `start_i` has no effect while a sequence runs, after done, or after a fault.
- R11: `cur_slot_o` reads 0 when idle and otherwise a slot number from 1 to N_SLOTS.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Request to begin the power-up sequence |
| slot_cfg_i | input | N_SUP*SLOT_W | Per-supply slot number, 0 = not sequenced |
| pgood_i | input | N_SUP | Per-supply power-good (output at 90% of target) |
| en_o | output | N_SUP | Per-supply enable |
| chip_on_o | output | 1 | Set when the sequence starts |
| cur_slot_o | output | SLOT_W | Current slot number |
| done_o | output | 1 | One-cycle pulse after the last slot |
| fault_o | output | 1 | Power-good timeout; sequence halted |

## Verification
The bench builds the block with six supplies, the full fourteen slots, a dwell of 8 cycles and a timeout of 5 cycles. It keeps the combinational enable variant. With such a short dwell, a whole fourteen-slot sequence fits in about a hundred cycles, so three complete runs fit in one bench. A 5-cycle timeout lets a modelled supply latency reach both sides of the fault boundary: a latency of 12 still advances and a latency of 13 faults. With four slot bits, a field value of 15 checks that a slot number past the last slot is never enabled.

// File: rtl/pwrup_pkg.sv
package pwrup_pkg;

   typedef enum logic [1:0] {
      SQ_IDLE  = 2'd0,
      SQ_RUN   = 2'd1,
      SQ_DONE  = 2'd2,
      SQ_FAULT = 2'd3
   } sq_state_e;

endpackage

// File: rtl/pwrup_slot_timer.sv
// Per-slot dwell and power-good timeout counter.
module pwrup_slot_timer #(
   parameter int SLOT_DLY = 1280,
   parameter int PG_TMO   = 640
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr_i,
   input  logic run_i,
   output logic dly_done_o,
   output logic tmo_hit_o
);
   localparam int LIM   = SLOT_DLY - 1 + PG_TMO;
   localparam int CNT_W = $clog2(LIM + 1);
   localparam logic [CNT_W-1:0] DLY_LAST = CNT_W'(SLOT_DLY - 1);
   localparam logic [CNT_W-1:0] CNT_LIM  = CNT_W'(LIM);

   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (clr_i) begin
         cnt_q <= '0;
      end else if (run_i && (cnt_q != CNT_LIM)) begin
         cnt_q <= cnt_q + 1'b1;
      end
   end

   assign dly_done_o = (cnt_q >= DLY_LAST);
   assign tmo_hit_o  = (cnt_q == CNT_LIM);

   // R8
   cnt_in_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q <= CNT_LIM);

   // R5
   cnt_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
      clr_i |=> (cnt_q == '0));

endmodule

// File: rtl/pwrup_slot_decode.sv
// Decodes per-supply slot fields into cumulative enables and the
// mask of supplies belonging to the current slot.
module pwrup_slot_decode #(
   parameter int N_SUP   = 8,
   parameter int N_SLOTS = 14,
   parameter int SLOT_W  = 4,
   parameter bit OUT_REG = 1'b0
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic [N_SUP*SLOT_W-1:0] cfg_i,
   input  logic [SLOT_W-1:0]       slot_i,
   input  logic                    active_i,
   output logic [N_SUP-1:0]        en_o,
   output logic [N_SUP-1:0]        grp_o
);
   localparam logic [SLOT_W-1:0] LAST_SLOT = SLOT_W'(N_SLOTS);

   for (genvar g = 0; g < N_SUP; g++) begin : g_sup
      logic [SLOT_W-1:0] cfg;
      logic              seq_ok;
      logic              en_d;

      assign cfg    = cfg_i[g*SLOT_W +: SLOT_W];
      assign seq_ok = (cfg != '0) && (cfg <= LAST_SLOT);
      assign en_d   = active_i && seq_ok && (cfg <= slot_i);
      assign grp_o[g] = seq_ok && (cfg == slot_i);

      if (OUT_REG) begin : g_reg
         logic en_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) en_q <= 1'b0;
            else        en_q <= en_d;
         end
         assign en_o[g] = en_q;
      end else begin : g_comb
         assign en_o[g] = en_d;
      end

      // R4
      unseq_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (!seq_ok && $stable(cfg)) |-> !en_o[g]);
   end

endmodule

// File: rtl/pwrup_seq.sv
module pwrup_seq
   import pwrup_pkg::*;
#(
   parameter int N_SUP    = 8,
   parameter int N_SLOTS  = 14,
   parameter int SLOT_DLY = 1280,
   parameter int PG_TMO   = 640,
   parameter bit OUT_REG  = 1'b0,
   localparam int SLOT_W  = $clog2(N_SLOTS + 1)
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    start_i,
   input  logic [N_SUP*SLOT_W-1:0] slot_cfg_i,
   input  logic [N_SUP-1:0]        pgood_i,
   output logic [N_SUP-1:0]        en_o,
   output logic                    chip_on_o,
   output logic [SLOT_W-1:0]       cur_slot_o,
   output logic                    done_o,
   output logic                    fault_o
);
   localparam logic [SLOT_W-1:0] LAST_SLOT = SLOT_W'(N_SLOTS);

   // elaboration-time parameter checks
   if (N_SUP < 1) begin : g_bad_sup
      $error("pwrup_seq: N_SUP must be at least 1");
   end
   if (N_SLOTS < 1) begin : g_bad_slots
      $error("pwrup_seq: N_SLOTS must be at least 1");
   end
   if (SLOT_DLY < 1 || PG_TMO < 1) begin : g_bad_time
      $error("pwrup_seq: SLOT_DLY and PG_TMO must be at least 1");
   end
   if (OUT_REG && SLOT_DLY < 2) begin : g_bad_reg
      $error("pwrup_seq: registered enables need SLOT_DLY >= 2");
   end

   sq_state_e         state_q;
   logic [SLOT_W-1:0] slot_q;
   logic              chip_on_q;
   logic              done_q;
   logic [N_SUP-1:0]  grp_mask;
   logic              all_pg;
   logic              dly_done;
   logic              tmo_hit;
   logic              accept;
   logic              adv;

   assign accept = (state_q == SQ_IDLE) && start_i;
   assign all_pg = &(pgood_i | ~grp_mask);
   assign adv    = (state_q == SQ_RUN) && dly_done && all_pg;

   pwrup_slot_timer #(
      .SLOT_DLY (SLOT_DLY),
      .PG_TMO   (PG_TMO)
   ) i_timer (
      .clk        (clk),
      .rst_n      (rst_n),
      .clr_i      (accept || adv),
      .run_i      (state_q == SQ_RUN),
      .dly_done_o (dly_done),
      .tmo_hit_o  (tmo_hit)
   );

   pwrup_slot_decode #(
      .N_SUP   (N_SUP),
      .N_SLOTS (N_SLOTS),
      .SLOT_W  (SLOT_W),
      .OUT_REG (OUT_REG)
   ) i_decode (
      .clk      (clk),
      .rst_n    (rst_n),
      .cfg_i    (slot_cfg_i),
      .slot_i   (slot_q),
      .active_i (state_q != SQ_IDLE),
      .en_o     (en_o),
      .grp_o    (grp_mask)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q   <= SQ_IDLE;
         slot_q    <= '0;
         chip_on_q <= 1'b0;
         done_q    <= 1'b0;
      end else begin
         done_q <= 1'b0;
         unique case (state_q)
            SQ_IDLE: begin
               if (start_i) begin
                  state_q   <= SQ_RUN;
                  slot_q    <= SLOT_W'(1);
                  chip_on_q <= 1'b1;
               end
            end
            SQ_RUN: begin
               if (adv) begin
                  if (slot_q == LAST_SLOT) begin
                     state_q <= SQ_DONE;
                     done_q  <= 1'b1;
                  end else begin
                     slot_q <= slot_q + 1'b1;
                  end
               end else if (tmo_hit) begin
                  state_q <= SQ_FAULT;
               end
            end
            default: ;
         endcase
      end
   end

   assign chip_on_o  = chip_on_q;
   assign cur_slot_o = slot_q;
   assign done_o     = done_q;
   assign fault_o    = (state_q == SQ_FAULT);

   // R2
   chip_on_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $past(chip_on_o) |-> chip_on_o);

   // R3
   en_cumulative_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (chip_on_o && $past(chip_on_o) && $stable(slot_cfg_i))
         |-> ((en_o & $past(en_o)) == $past(en_o)));

   // R6
   adv_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(state_q == SQ_RUN) && (slot_q != $past(slot_q)))
         |-> $past(dly_done && all_pg));

   // R8
   fault_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $past(fault_o) |-> (fault_o && $stable(cur_slot_o) && !done_o));

   // R9
   done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o);

   // R11
   slot_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cur_slot_o <= LAST_SLOT) && ((cur_slot_o == '0) == !chip_on_o));

endmodule

// File: tb/test_pwrup_seq.sv
module test_pwrup_seq;
   localparam int NS    = 6;
   localparam int SLOTS = 14;
   localparam int DLY   = 8;
   localparam int TMO   = 5;
   localparam int SW    = 4;
   localparam int FAULT_CODE = 100;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             start = 1'b0;
   logic [NS*SW-1:0] cfg;
   logic [NS-1:0]    pgood;
   logic [NS-1:0]    en;
   logic             chip_on;
   logic [SW-1:0]    cur_slot;
   logic             done;
   logic             fault;

   int cfgv [NS];
   int lat  [NS];
   int pcnt [NS];

   int n_tests = 0;
   int n_fail  = 0;

   typedef struct {
      int            slot;
      logic [NS-1:0] en;
      int            dw;
      string         req;
   } exp_t;
   exp_t q[$];

   always #2 clk = ~clk;

   pwrup_seq #(
      .N_SUP    (NS),
      .N_SLOTS  (SLOTS),
      .SLOT_DLY (DLY),
      .PG_TMO   (TMO),
      .OUT_REG  (1'b0)
   ) i_pwrup_seq (
      .clk        (clk),
      .rst_n      (rst_n),
      .start_i    (start),
      .slot_cfg_i (cfg),
      .pgood_i    (pgood),
      .en_o       (en),
      .chip_on_o  (chip_on),
      .cur_slot_o (cur_slot),
      .done_o     (done),
      .fault_o    (fault)
   );

   // supply model: good a fixed number of cycles after enable
   always @(posedge clk) begin
      for (int i = 0; i < NS; i++) begin
         if (!en[i])              pcnt[i] <= 0;
         else if (pcnt[i] < 1000) pcnt[i] <= pcnt[i] + 1;
      end
   end

   always_comb begin
      for (int i = 0; i < NS; i++) pgood[i] = en[i] && (pcnt[i] >= lat[i]);
   end

   task automatic chk(input bit ok, input string req, input string what,
                      input longint act, input longint exp);
      n_tests++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   function automatic logic [NS-1:0] exp_en(input int s);
      logic [NS-1:0] r = '0;
      for (int i = 0; i < NS; i++)
         r[i] = (cfgv[i] >= 1) && (cfgv[i] <= SLOTS) && (cfgv[i] <= s);
      return r;
   endfunction

   // driver: expected slot transitions, done and fault events
   task automatic plan_seq();
      for (int s = 1; s <= SLOTS; s++) begin
         int   mx = -1;
         int   j;
         exp_t e;
         for (int i = 0; i < NS; i++)
            if (cfgv[i] == s && lat[i] > mx) mx = lat[i];
         if (mx > DLY - 1 + TMO) begin
            e.slot = FAULT_CODE; e.en = exp_en(s); e.dw = DLY + TMO; e.req = "R8";
            q.push_back(e);
            return;
         end
         j = (mx > DLY - 1) ? mx : DLY - 1;
         e.slot = s + 1;
         e.en   = exp_en((s == SLOTS) ? SLOTS : s + 1);
         e.dw   = j + 1;
         if (s == SLOTS)    e.req = "R9";
         else if (mx < 0)   e.req = "R7";
         else if (mx > DLY - 1) e.req = "R6";
         else               e.req = "R5";
         q.push_back(e);
      end
   endtask

   // monitor: compares observed events with the queue
   int  mon_prev = 0;
   int  mon_dw   = 0;
   bit  mon_pdone = 0;
   bit  mon_pfault = 0;

   task automatic observe(input int slot, input logic [NS-1:0] e_now, input int dw);
      exp_t e;
      if (q.size() == 0) begin
         chk(1'b0, "R11", "unexpected event slot", slot, -1);
         return;
      end
      e = q.pop_front();
      chk(slot == e.slot, e.req, "event slot", slot, e.slot);
      chk(e_now == e.en, "R3", "enables at event", e_now, e.en);
      chk(dw == e.dw, e.req, "slot dwell", dw, e.dw);
   endtask

   always @(negedge clk) begin
      if (!rst_n) begin
         mon_prev = 0; mon_dw = 0; mon_pdone = 0; mon_pfault = 0;
      end else begin
         mon_dw++;
         if (int'(cur_slot) != mon_prev) begin
            if (mon_prev != 0) observe(int'(cur_slot), en, mon_dw);
            mon_dw   = 0;
            mon_prev = int'(cur_slot);
         end
         if (done && !mon_pdone)   observe(SLOTS + 1, en, mon_dw);
         if (fault && !mon_pfault) observe(FAULT_CODE, en, mon_dw);
         if (mon_pdone) chk(!done, "R9", "done pulse width", done, 0);
         mon_pdone  = done;
         mon_pfault = fault;
      end
   end

   task automatic setup(input int c0, input int c1, input int c2, input int c3,
                        input int c4, input int c5, input int l0, input int l1,
                        input int l2, input int l3, input int l4, input int l5);
      cfgv = '{c0, c1, c2, c3, c4, c5};
      lat  = '{l0, l1, l2, l3, l4, l5};
      for (int i = 0; i < NS; i++) cfg[i*SW +: SW] = SW'(cfgv[i]);
      q.delete();
      rst_n = 1'b0;
      start = 1'b0;
      repeat (3) @(negedge clk);
      // R1
      chk(en == '0, "R1", "reset enables", en, 0);
      chk(!chip_on && !done && !fault, "R1", "reset flags", {chip_on, done, fault}, 0);
      chk(cur_slot == '0, "R1", "reset slot", cur_slot, 0);
      rst_n = 1'b1;
      repeat (4) @(negedge clk);
      chk(cur_slot == '0 && en == '0 && !chip_on, "R1", "idle without start",
          {cur_slot, en}, 0);
      plan_seq();
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      // R2
      chk(chip_on, "R2", "chip_on after start", chip_on, 1);
      chk(cur_slot == SW'(1), "R2", "first slot", cur_slot, 1);
      chk(en == exp_en(1), "R3", "slot 1 enables", en, exp_en(1));
   endtask

   task automatic wait_drain();
      int k = 0;
      while (q.size() != 0 && k < 3000) begin
         @(negedge clk);
         k++;
      end
      chk(q.size() == 0, "R5", "pending events", q.size(), 0);
   endtask

   task automatic pulse_start();
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
   endtask

   initial begin
      cfg = '0;
      for (int i = 0; i < NS; i++) begin lat[i] = 0; cfgv[i] = 0; end

      // scenario A: immediate good, empty slots, unsequenced supply
      setup(1, 3, 3, 0, 14, 7, 0, 0, 0, 0, 0, 0);
      while (cur_slot != SW'(5)) @(negedge clk);
      pulse_start();   // R10 ignored mid-run; dwell checks would catch a restart
      wait_drain();
      pulse_start();
      repeat (3) @(negedge clk);
      chk(cur_slot == SW'(SLOTS) && !done && chip_on, "R10", "start after done",
          cur_slot, SLOTS);
      chk(en == 6'b110111, "R4", "slot field 0 stays off", en, 6'b110111);

      // scenario B: late good in grouped slots, out-of-range field, timeout boundary
      setup(2, 2, 5, 9, 15, 0, 3, 10, 0, 12, 0, 0);
      wait_drain();
      repeat (2) @(negedge clk);
      chk(en == 6'b001111, "R4", "field above last slot stays off", en, 6'b001111);
      chk(!fault, "R8", "good at timeout edge advances", fault, 0);

      // scenario C: supply never good in time
      setup(1, 4, 4, 0, 0, 6, 0, 2, 13, 0, 0, 0);
      wait_drain();
      repeat (20) @(negedge clk);
      chk(fault, "R8", "fault held", fault, 1);
      chk(cur_slot == SW'(4), "R8", "slot frozen", cur_slot, 4);
      chk(en == exp_en(4), "R8", "enables held", en, exp_en(4));
      pulse_start();
      repeat (3) @(negedge clk);
      chk(cur_slot == SW'(4) && fault && !done, "R10", "start after fault", cur_slot, 4);

      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      n_tests++;
      n_fail++;
      $display("FAIL R9 watchdog: actual hung expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

endmodule